// File: doc/BRIEF.md
# Burst DMA Channel Engine

This block is a small multi-channel DMA engine that moves data in burst mode over a 16-bit synchronous bus. Each channel holds an enable bit, a unit size (byte or word), a transfer-end enable, a source address, a destination address and a unit count. Software loads these fields through a single-cycle configuration write port. When the bus is released, the engine picks the lowest-numbered channel that is requesting, enabled and has a non-zero count. It then asks for the bus and, once granted, runs that channel's units back to back until the count is used up.

Every unit is a two-state read at the source address followed by a two-state write at the destination address. The read data is held in an internal register between the two accesses. While a burst runs, every other request waits, whatever its priority. An NMI clears every channel's enable bit. A running burst still finishes the unit it is in, then releases the bus and leaves its addresses and count where the last completed unit put them. A transfer-end strobe can mark the final unit of a burst.

Top module: `burst_dma_engine`

## Requirements
- R1: After reset, bus_req, bus_rd, bus_wr_hi, bus_wr_lo and tend are 0, every bit of en_o is 0, and every channel reads back with source, destination and count equal to 0.
- R2: A burst holds bus_req high for one cycle before its first unit, and no unit starts while bus_gnt is 0. Each unit drives bus_rd for exactly 2 cycles with bus_addr at the source, then write strobes for exactly 2 cycles with bus_addr at the destination. The data written is the data captured at the end of the read. A burst of N units keeps bus_req high for exactly 1+4N cycles.
- R3: Units follow each other with no cycle between them and without dropping bus_req until the count reaches 0. After each unit, source and destination each advance by the unit size (2 for word, 1 for byte) and the count drops by 1.
- R4: A word unit (cfg_word=1) drives both bus_wr_hi and bus_wr_lo. A byte unit drives only bus_wr_hi when destination bit 0 is 0, and only bus_wr_lo when it is 1. A byte read takes bus_rdata[15:8] when source bit 0 is 0 and bus_rdata[7:0] when it is 1, and writes that byte on both lanes of bus_wdata.
- R5: With the bus released, the lowest-numbered channel whose req, enable and non-zero count are all present is served first.
- R6: While a burst runs, requests from other channels, including lower-numbered ones, are not served until bus_req has dropped. They are served afterwards.
- R7: A cycle with nmi=1 clears every bit of en_o at the next clock edge. A running burst completes its current unit, then drops bus_req. The channel's count, source and destination reflect only the completed units.
- R8: When nmi arrives during the final unit (the unit that starts with count 1), that unit completes, the count reaches 0 and the strobe of R9 still covers that unit.
- R9: With the transfer-end enable set, tend is 1 during exactly the 4 cycles of the final unit of a burst. It is never 1 when the enable is clear, and never during a burst cut short before its final unit.
- R10: A configuration write addressed to the channel that is running has no effect. In a cycle where nmi=1, a write cannot set an enable bit. Writes to other channels take effect at the next edge.
- R11: The readback outputs rd_src, rd_dst and rd_cnt show the fields of channel rd_sel one cycle after rd_sel is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NCH | Per-channel transfer request, level sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the configuration write |
| cfg_en | input | 1 | Enable bit to load |
| cfg_word | input | 1 | Unit size to load: 1 word, 0 byte |
| cfg_tend | input | 1 | Transfer-end strobe enable to load |
| cfg_src | input | AW | Source address to load |
| cfg_dst | input | AW | Destination address to load |
| cfg_cnt | input | CW | Unit count to load |
| rd_sel | input | CHW | Channel shown on the readback outputs |
| rd_src | output | AW | Source address of the selected channel |
| rd_dst | output | AW | Destination address of the selected channel |
| rd_cnt | output | CW | Remaining count of the selected channel |
| en_o | output | NCH | Enable bits of all channels |
| nmi | input | 1 | Non-maskable abort |
| bus_req | output | 1 | Bus request, high for the whole burst |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr_hi | output | 1 | Write strobe for bits 15:8 |
| bus_wr_lo | output | 1 | Write strobe for bits 7:0 |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of the second read state |
| tend | output | 1 | Transfer-end strobe |

## Verification
Timing is the same for every channel and unit size:
- bus_req rises one cycle after a qualifying request is seen with the bus released.
- The first read state follows one cycle after the grant.
- Each unit then takes exactly four cycles, so unit k of a burst begins on cycle 1+4(k-1) counted from the request cycle.
- An enable bit falls one edge after nmi.
- Readback is due one edge after rd_sel changes.

The bench drives inputs just after the falling edge and samples outputs on the falling edge, one full state after each edge. At every falling edge it counts request cycles, read starts, strobe cycles per lane and transfer-end cycles. The checks compare these counts, and the position of the first transfer-end cycle, with values computed from these offsets.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD1,
    ST_RD2,
    ST_WR1,
    ST_WR2
  } seq_state_t;
endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] cand,
  output logic           any,
  output logic [CHW-1:0] idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 3,
  parameter int CHW = 2,
  parameter int AW  = 16,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           nmi,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic           cfg_en,
  input  logic           cfg_word,
  input  logic           cfg_tend,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic           busy,
  input  logic [CHW-1:0] act_ch,
  input  logic           step,
  output logic [NCH-1:0] en_v,
  output logic [NCH-1:0] word_v,
  output logic [NCH-1:0] tend_v,
  output logic [AW-1:0]  src_a [NCH],
  output logic [AW-1:0]  dst_a [NCH],
  output logic [CW-1:0]  cnt_a [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          load, adv;
    logic          en_q, word_q, tend_q;
    logic [AW-1:0] src_q, dst_q, inc;
    logic [CW-1:0] cnt_q;

    // the running channel is locked against software writes
    assign load = cfg_we && (cfg_ch == CHW'(g)) && !(busy && (act_ch == CHW'(g)));
    assign adv  = step && (act_ch == CHW'(g));
    assign inc  = word_q ? AW'(2) : AW'(1);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q   <= 1'b0;
        word_q <= 1'b0;
        tend_q <= 1'b0;
        src_q  <= '0;
        dst_q  <= '0;
        cnt_q  <= '0;
      end else begin
        if (load) begin
          word_q <= cfg_word;
          tend_q <= cfg_tend;
          src_q  <= cfg_src;
          dst_q  <= cfg_dst;
          cnt_q  <= cfg_cnt;
        end else if (adv) begin
          src_q  <= src_q + inc;
          dst_q  <= dst_q + inc;
          cnt_q  <= cnt_q - 1'b1;
        end
        if (nmi)       en_q <= 1'b0;
        else if (load) en_q <= cfg_en;
      end
    end

    assign en_v[g]   = en_q;
    assign word_v[g] = word_q;
    assign tend_v[g] = tend_q;
    assign src_a[g]  = src_q;
    assign dst_a[g]  = dst_q;
    assign cnt_a[g]  = cnt_q;
  end
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CHW = 2,
  parameter int AW  = 16,
  parameter int CW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi,
  input  logic             cand_any,
  input  logic [CHW-1:0]   cand_idx,
  input  logic [NCH-1:0]   en_v,
  input  logic [NCH-1:0]   word_v,
  input  logic [NCH-1:0]   tend_v,
  input  logic [AW-1:0]    src_a [NCH],
  input  logic [AW-1:0]    dst_a [NCH],
  input  logic [CW-1:0]    cnt_a [NCH],
  input  logic             bus_gnt,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic             busy,
  output logic [CHW-1:0]   act_ch,
  output logic             step,
  output logic             bus_req,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr_hi,
  output logic             bus_wr_lo,
  output logic [BUS_W-1:0] bus_wdata,
  output logic             tend
);
  seq_state_t       state;
  logic [CHW-1:0]   ch_q;
  logic [BUS_W-1:0] hold_q;

  logic             en_c, word_c, tend_c, cont;
  logic [AW-1:0]    src_c, dst_c, inc;
  logic [CW-1:0]    cnt_c;
  logic [7:0]       byte_pick;
  logic [BUS_W-1:0] captured;

  always_comb begin
    en_c      = en_v[ch_q];
    word_c    = word_v[ch_q];
    tend_c    = tend_v[ch_q];
    src_c     = src_a[ch_q];
    dst_c     = dst_a[ch_q];
    cnt_c     = cnt_a[ch_q];
    inc       = word_c ? AW'(2) : AW'(1);
    byte_pick = src_c[0] ? bus_rdata[7:0] : bus_rdata[15:8];
    captured  = word_c ? bus_rdata : {byte_pick, byte_pick};
    // another unit follows only if enabled, no abort, and more than one left
    cont      = en_c && !nmi && (cnt_c > CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ch_q      <= '0;
      hold_q    <= '0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr_hi <= 1'b0;
      bus_wr_lo <= 1'b0;
      tend      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cand_any && !nmi) begin
            state   <= ST_REQ;
            ch_q    <= cand_idx;
            bus_req <= 1'b1;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            if (en_c && !nmi && (cnt_c != '0)) begin
              state    <= ST_RD1;
              bus_addr <= src_c;
              bus_rd   <= 1'b1;
              tend     <= tend_c && (cnt_c == CW'(1));
            end else begin
              state    <= ST_IDLE;
              bus_req  <= 1'b0;
            end
          end
        end
        ST_RD1: state <= ST_RD2;
        ST_RD2: begin
          state     <= ST_WR1;
          hold_q    <= captured;
          bus_rd    <= 1'b0;
          bus_addr  <= dst_c;
          bus_wr_hi <= word_c || !dst_c[0];
          bus_wr_lo <= word_c || dst_c[0];
        end
        ST_WR1: state <= ST_WR2;
        ST_WR2: begin
          bus_wr_hi <= 1'b0;
          bus_wr_lo <= 1'b0;
          if (cont) begin
            state    <= ST_RD1;
            bus_addr <= src_c + inc;
            bus_rd   <= 1'b1;
            tend     <= tend_c && (cnt_c == CW'(2));
          end else begin
            state    <= ST_IDLE;
            bus_req  <= 1'b0;
            bus_addr <= '0;
            tend     <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign act_ch    = ch_q;
  assign step      = (state == ST_WR2);
  assign bus_wdata = hold_q;
endmodule

// File: rtl/burst_dma_engine.sv
module burst_dma_engine
  import dma_pkg::*;
#(
  parameter  int NCH = 3,
  parameter  int AW  = 16,
  parameter  int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   req,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic             cfg_en,
  input  logic             cfg_word,
  input  logic             cfg_tend,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [CW-1:0]    cfg_cnt,
  input  logic [CHW-1:0]   rd_sel,
  output logic [AW-1:0]    rd_src,
  output logic [AW-1:0]    rd_dst,
  output logic [CW-1:0]    rd_cnt,
  output logic [NCH-1:0]   en_o,
  input  logic             nmi,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr_hi,
  output logic             bus_wr_lo,
  output logic [BUS_W-1:0] bus_wdata,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic             tend
);
  logic [NCH-1:0] en_v, word_v, tend_v, cand;
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [CW-1:0]  cnt_a [NCH];
  logic           seq_busy, seq_step, cand_any;
  logic [CHW-1:0] seq_ch, cand_idx;

  dma_chan_regs #(.NCH(NCH), .CHW(CHW), .AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst(rst), .nmi(nmi),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en), .cfg_word(cfg_word),
    .cfg_tend(cfg_tend), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .busy(seq_busy), .act_ch(seq_ch), .step(seq_step),
    .en_v(en_v), .word_v(word_v), .tend_v(tend_v),
    .src_a(src_a), .dst_a(dst_a), .cnt_a(cnt_a)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_cand
    assign cand[g] = req[g] && en_v[g] && (cnt_a[g] != '0);
  end

  dma_arbiter #(.NCH(NCH), .CHW(CHW)) arb_i (
    .cand(cand), .any(cand_any), .idx(cand_idx)
  );

  dma_bus_seq #(.NCH(NCH), .CHW(CHW), .AW(AW), .CW(CW)) seq_i (
    .clk(clk), .rst(rst), .nmi(nmi),
    .cand_any(cand_any), .cand_idx(cand_idx),
    .en_v(en_v), .word_v(word_v), .tend_v(tend_v),
    .src_a(src_a), .dst_a(dst_a), .cnt_a(cnt_a),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .busy(seq_busy), .act_ch(seq_ch), .step(seq_step),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr_hi(bus_wr_hi), .bus_wr_lo(bus_wr_lo),
    .bus_wdata(bus_wdata), .tend(tend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src <= '0;
      rd_dst <= '0;
      rd_cnt <= '0;
    end else if (int'(rd_sel) < NCH) begin
      rd_src <= src_a[rd_sel];
      rd_dst <= dst_a[rd_sel];
      rd_cnt <= cnt_a[rd_sel];
    end
  end

  assign en_o = en_v;
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           nmi,
  input logic [NCH-1:0] en_o,
  input logic           bus_req,
  input logic           bus_rd,
  input logic           bus_wr_hi,
  input logic           bus_wr_lo,
  input logic           tend,
  input logic           busy,
  input logic [CHW-1:0] act_ch
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (!bus_rd && !bus_wr_hi && !bus_wr_lo && !tend));

  p_read_two_states_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |=> bus_rd);

  p_write_two_states_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_hi || bus_wr_lo) |=> (bus_wr_hi || bus_wr_lo));

  p_write_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd) |-> (bus_wr_hi || bus_wr_lo));

  p_no_rd_wr_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && (bus_wr_hi || bus_wr_lo)));

  p_channel_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(act_ch));

  p_nmi_clears_r7: assert property (@(posedge clk) disable iff (rst)
    nmi |=> (en_o == '0));

  p_tend_in_unit_r9: assert property (@(posedge clk) disable iff (rst)
    tend |-> (bus_req && (bus_rd || bus_wr_hi || bus_wr_lo)));
endmodule

bind burst_dma_engine dma_checker #(.NCH(NCH), .CHW(CHW)) chk_i (
  .clk(clk), .rst(rst), .nmi(nmi), .en_o(en_o), .bus_req(bus_req),
  .bus_rd(bus_rd), .bus_wr_hi(bus_wr_hi), .bus_wr_lo(bus_wr_lo),
  .tend(tend), .busy(seq_busy), .act_ch(seq_ch)
);

// File: tb/burst_dma_engine_tb_top.sv
`timescale 1ns/1ps
module burst_dma_engine_tb_top;
  localparam int NCH = 3;
  localparam int AW  = 16;
  localparam int CW  = 8;
  localparam int CHW = 2;
  localparam int NV  = 6;

  // {channel[23:22], word[21], tend_en[20], src[19:12], dst[11:4], count[3:0]}
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b1, 8'h00, 8'h80, 4'd4},
    {2'd1, 1'b0, 1'b1, 8'h10, 8'h90, 4'd5},
    {2'd2, 1'b0, 1'b0, 8'h21, 8'hA3, 4'd3},
    {2'd0, 1'b1, 1'b0, 8'h30, 8'hB0, 4'd1},
    {2'd1, 1'b0, 1'b1, 8'h41, 8'hC0, 4'd2},
    {2'd2, 1'b1, 1'b1, 8'h50, 8'hD0, 4'd6}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] req = '0;
  logic           cfg_we = 1'b0, cfg_en = 1'b0, cfg_word = 1'b0, cfg_tend = 1'b0;
  logic [CHW-1:0] cfg_ch = '0, rd_sel = '0;
  logic [AW-1:0]  cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0]  cfg_cnt = '0;
  logic [AW-1:0]  rd_src, rd_dst, bus_addr;
  logic [CW-1:0]  rd_cnt;
  logic [NCH-1:0] en_o;
  logic           nmi = 1'b0, bus_gnt = 1'b1;
  logic           bus_req, bus_rd, bus_wr_hi, bus_wr_lo, tend;
  logic [15:0]    bus_wdata, bus_rdata;

  logic [7:0] mem [256];
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 1'b0;
  int units, breq_cyc, tend_cnt, tend_at, hi_cyc, lo_cyc, first_addr;
  logic prev_rd = 1'b0;

  always #2.5 clk = ~clk;

  assign bus_rdata = {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};

  burst_dma_engine #(.NCH(NCH), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_en(cfg_en), .cfg_word(cfg_word), .cfg_tend(cfg_tend),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .rd_sel(rd_sel), .rd_src(rd_src), .rd_dst(rd_dst), .rd_cnt(rd_cnt),
    .en_o(en_o), .nmi(nmi), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr_hi(bus_wr_hi),
    .bus_wr_lo(bus_wr_lo), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tend(tend)
  );

  // bus monitor and memory model, sampled between edges
  always @(negedge clk) begin
    if (bus_req) begin
      if (tend && tend_cnt == 0) tend_at = breq_cyc;
      if (tend) tend_cnt++;
      breq_cyc++;
    end
    if (bus_rd && !prev_rd) begin
      if (units == 0) first_addr = int'(bus_addr);
      units++;
    end
    prev_rd = bus_rd;
    if (bus_wr_hi) begin mem[{bus_addr[7:1], 1'b0}] = bus_wdata[15:8]; hi_cyc++; end
    if (bus_wr_lo) begin mem[{bus_addr[7:1], 1'b1}] = bus_wdata[7:0];  lo_cyc++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog (all requirements): actual cycles=%0d expected<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
  endtask

  task automatic clr_mon();
    units = 0; breq_cyc = 0; tend_cnt = 0; tend_at = -1;
    hi_cyc = 0; lo_cyc = 0; first_addr = -1;
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic prog(input int ch, input bit en, input bit w, input bit t,
                      input int src, input int dst, input int cnt);
    cfg_ch = CHW'(ch); cfg_en = en; cfg_word = w; cfg_tend = t;
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_cnt = CW'(cnt);
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic readback(input int ch);
    rd_sel = CHW'(ch);
    tick();
  endtask

  task automatic run_until_release();
    for (int i = 0; i < 600 && !bus_req; i++) tick();
    for (int i = 0; i < 600 && bus_req; i++) tick();
  endtask

  task automatic wait_units(input int n);
    for (int i = 0; i < 600 && units < n; i++) tick();
  endtask

  initial begin
    logic [23:0] e;
    int ch, cnt, src, dst, sz, nb, bad, eh, el;
    clr_mon();
    init_mem();
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1 bus_req after reset", int'(bus_req), 0);
    chk("R1 strobes after reset", int'({bus_rd, bus_wr_hi, bus_wr_lo, tend}), 0);
    chk("R1 en_o after reset", int'(en_o), 0);
    readback(1);
    chk("R1 readback after reset", int'(rd_src) + int'(rd_dst) + int'(rd_cnt), 0);

    // table of bursts: R2 R3 R4 R9 R11
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      ch = int'(e[23:22]); src = int'(e[19:12]); dst = int'(e[11:4]); cnt = int'(e[3:0]);
      sz = e[21] ? 2 : 1; nb = cnt * sz;
      init_mem();
      prog(ch, 1'b1, e[21], e[20], src, dst, cnt);
      clr_mon();
      req[ch] = 1'b1;
      run_until_release();
      req = '0;
      chk("R3 units in burst", units, cnt);
      chk("R2 R3 bus_req cycles", breq_cyc, 1 + 4 * cnt);
      chk("R5 first read address", first_addr, src);
      bad = 0;
      for (int k = 0; k < nb; k++) if (mem[dst + k] != pat(src + k)) bad++;
      chk("R2 R4 copied bytes wrong", bad, 0);
      eh = 0; el = 0;
      for (int k = 0; k < cnt; k++) begin
        if (e[21]) begin eh += 2; el += 2; end
        else if (((dst + k) % 2) == 0) eh += 2;
        else el += 2;
      end
      chk("R4 high strobe cycles", hi_cyc, eh);
      chk("R4 low strobe cycles", lo_cyc, el);
      chk("R9 tend cycles", tend_cnt, e[20] ? 4 : 0);
      if (e[20]) chk("R9 tend position", tend_at, 1 + 4 * (cnt - 1));
      readback(ch);
      chk("R3 R11 final count", int'(rd_cnt), 0);
      chk("R3 R11 final source", int'(rd_src), src + nb);
      chk("R3 R11 final destination", int'(rd_dst), dst + nb);
    end

    // R5 and grant wait (R2): two channels request together
    init_mem();
    prog(0, 1'b1, 1'b1, 1'b0, 8'h20, 8'hA0, 1);
    prog(2, 1'b1, 1'b1, 1'b0, 8'h30, 8'hB0, 1);
    bus_gnt = 1'b0;
    clr_mon();
    req[0] = 1'b1; req[2] = 1'b1;
    repeat (6) tick();
    chk("R2 bus_req while grant low", int'(bus_req), 1);
    chk("R2 no read without grant", units, 0);
    bus_gnt = 1'b1;
    run_until_release();
    chk("R5 lowest channel first", first_addr, 8'h20);
    clr_mon();
    run_until_release();
    chk("R5 second channel next", first_addr, 8'h30);
    req = '0;

    // R6: lower-numbered request during a burst waits
    init_mem();
    prog(1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h80, 4);
    prog(0, 1'b1, 1'b1, 1'b0, 8'h10, 8'h90, 2);
    clr_mon();
    req[1] = 1'b1;
    wait_units(1);
    req[0] = 1'b1;
    run_until_release();
    chk("R6 running burst not preempted", units, 4);
    chk("R6 running burst address", first_addr, 8'h00);
    clr_mon();
    run_until_release();
    chk("R6 pending request served after release", first_addr, 8'h10);
    chk("R6 pending burst length", units, 2);
    req = '0;

    // R7 R9: nmi in the middle of a burst
    init_mem();
    prog(0, 1'b1, 1'b0, 1'b1, 8'h60, 8'hE0, 5);
    clr_mon();
    req[0] = 1'b1;
    wait_units(2);
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
    chk("R7 enable cleared", int'(en_o[0]), 0);
    run_until_release();
    req = '0;
    chk("R7 units completed", units, 2);
    chk("R9 no tend on aborted burst", tend_cnt, 0);
    readback(0);
    chk("R7 count after abort", int'(rd_cnt), 3);
    chk("R7 source after abort", int'(rd_src), 8'h62);
    chk("R7 destination after abort", int'(rd_dst), 8'hE2);
    chk("R7 completed bytes", int'(mem[8'hE1]), int'(pat(8'h61)));
    chk("R7 abandoned byte untouched", int'(mem[8'hE2]), int'(pat(8'hE2)));

    // R8: nmi during the final unit
    init_mem();
    prog(1, 1'b1, 1'b1, 1'b1, 8'h70, 8'hF0, 2);
    clr_mon();
    req[1] = 1'b1;
    wait_units(2);
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
    run_until_release();
    req = '0;
    chk("R8 final unit completes", units, 2);
    chk("R8 final word written", int'({mem[8'hF2], mem[8'hF3]}), int'({pat(8'h72), pat(8'h73)}));
    chk("R8 tend still marks final unit", tend_cnt, 4);
    readback(1);
    chk("R8 count reaches zero", int'(rd_cnt), 0);
    chk("R8 enable cleared", int'(en_o[1]), 0);

    // R10: write to the running channel is ignored
    init_mem();
    prog(0, 1'b1, 1'b1, 1'b0, 8'h40, 8'hC0, 3);
    clr_mon();
    req[0] = 1'b1;
    wait_units(1);
    prog(0, 1'b1, 1'b1, 1'b0, 8'h7E, 8'h7E, 9);
    run_until_release();
    req = '0;
    chk("R10 burst length unchanged", units, 3);
    readback(0);
    chk("R10 count unaffected by write", int'(rd_cnt), 0);
    chk("R10 source unaffected by write", int'(rd_src), 8'h46);
    nmi = 1'b1;
    prog(2, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1);
    nmi = 1'b0;
    chk("R10 nmi beats enable write", int'(en_o[2]), 0);
    prog(2, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1);
    chk("R10 idle channel write accepted", int'(en_o[2]), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule